// File: doc/BRIEF.md
# Register-Mapped SPI Byte Shifter

This block lets host software exchange bytes with a serial flash without toggling pins one at a time. The host sees two registers on a simple write/read port. A control register holds a chip-select level that only the host changes, and a read-only completion flag. A data register starts one transfer when written, and holds the returned byte when read.

Each write to the data register starts one full-duplex 8-bit exchange in SPI mode 0, most significant bit first. The serial clock runs at the system clock divided by six. During the exchange the completion flag reads 0. When the eighth bit is done the flag reads 1 again. A flash command is sent as a host sequence: the host drives chip-select low, does one write, poll and read per byte, then drives chip-select high.

Top module: `spi_byte_bridge`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, and the control register reads 0x1 (CS level 1, DAV 0).
- R2: cs_n equals the last value written to bit 0 of the control register. Byte transfers never change it.
- R3: A write to the data register while idle clears DAV (control bit 1) so that it reads 0 in the next cycle.
- R4: The written byte appears on mosi most significant bit first. mosi changes only on falling sclk edges and is stable while sclk is high.
- R5: Each transfer gives exactly 8 sclk pulses, each 3 system clocks high and 3 low, and sclk idles low.
- R6: DAV reads 1 exactly 48 system clocks after the clock edge that accepted the data write.
- R7: Once DAV is 1, the data register reads back the 8 bits sampled from miso on the rising sclk edges, first bit as the most significant.
- R8: A data-register write that arrives while DAV is 0 is ignored: the transfer in progress keeps its byte and its timing, and no extra transfer follows.
- R9: The control register is at offset 0x70 (bit 0 CS level, bit 1 DAV) and the data register is at 0x74. A write to any other offset changes nothing, and a read of it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select, host-owned |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is a data write that lands in the middle of a transfer. It must leave the bit counter, the phase and the outgoing byte untouched. The stimulus issues a second write twelve clocks after the first and uses a different byte. The bench then checks that the slave model received only the first byte and that DAV still rises on the 48th clock counted from the original write. A slave model returns a different pattern on each exchange, so an error in the receive path or the bit order shows up as a wrong read-back value.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
    localparam int unsigned XFER_W   = 8;
    localparam int unsigned SCK_DIV  = 6;
    localparam logic [7:0]  CTRL_OFS = 8'h70;
    localparam logic [7:0]  DATA_OFS = 8'h74;
    localparam int unsigned CS_POS   = 0;
    localparam int unsigned DONE_POS = 1;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int unsigned DIV = spi_bridge_pkg::SCK_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } div_t;

    div_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!run_i || st_q.ph == PH_LAST) st_d.ph = '0;
        else                              st_d.ph = st_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = run_i && (st_q.ph == PH_RISE);
    assign fall_o = run_i && (st_q.ph == PH_LAST);

    // R5: phase never leaves its range and rests at zero while idle
    a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= PH_LAST);
    a_r5_idle_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_q.ph == '0);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int unsigned W = spi_bridge_pkg::XFER_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] tx_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         miso_i,
    output logic         busy_o,
    output logic         dav_o,
    output logic         sclk_o,
    output logic         mosi_o,
    output logic [W-1:0] rx_o
);
    localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             busy;
        logic             dav;
        logic             sclk;
        logic             rx_bit;
        logic [W-1:0]     sh;
        logic [CNT_W-1:0] cnt;
    } eng_t;

    eng_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.dav  = 1'b0;
                st_d.sh   = tx_i;
                st_d.cnt  = '0;
                st_d.sclk = 1'b0;
            end
        end else begin
            if (rise_i) begin
                st_d.sclk   = 1'b1;
                st_d.rx_bit = miso_i;
            end
            if (fall_i) begin
                st_d.sclk = 1'b0;
                st_d.sh   = {st_q.sh[W-2:0], st_q.rx_bit};
                if (st_q.cnt == CNT_LAST) begin
                    st_d.cnt  = '0;
                    st_d.busy = 1'b0;
                    st_d.dav  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign dav_o  = st_q.dav;
    assign sclk_o = st_q.sclk;
    assign mosi_o = st_q.busy & st_q.sh[W-1];
    assign rx_o   = st_q.sh;

    // R3: an accepted start drops the done flag on the next cycle
    a_r3_start_clears_dav: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.busy) |=> (!dav_o && busy_o));
    // R4: outgoing data holds steady across the sclk high phase
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
    // R5: sclk is low whenever no transfer runs
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);
    // R6: done and busy are never both set
    a_r6_dav_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && dav_o));
    // R8: a start request during a transfer does not disturb the bit count
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !fall_i) |=> (st_q.cnt == $past(st_q.cnt) && busy_o));
endmodule

// File: rtl/spi_bridge_regs.sv
module spi_bridge_regs #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned W      = spi_bridge_pkg::XFER_W,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(spi_bridge_pkg::CTRL_OFS),
    parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(spi_bridge_pkg::DATA_OFS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              dav_i,
    input  logic [W-1:0]      rx_i,
    output logic              cs_n_o,
    output logic              start_o,
    output logic [W-1:0]      tx_o,
    output logic [BUS_W-1:0]  rdata_o
);
    import spi_bridge_pkg::*;

    typedef struct packed {
        logic cs_lvl;
    } reg_t;

    reg_t st_q, st_d;
    logic ctrl_wr;

    assign ctrl_wr = wr_i && (addr_i == CTRL_ADDR);

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.cs_lvl = wdata_i[CS_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_lvl: 1'b1};
        else        st_q <= st_d;
    end

    assign cs_n_o  = st_q.cs_lvl;
    assign start_o = wr_i && (addr_i == DATA_ADDR);
    assign tx_o    = wdata_i[W-1:0];

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) begin
            rdata_o[CS_POS]   = st_q.cs_lvl;
            rdata_o[DONE_POS] = dav_i;
        end else if (addr_i == DATA_ADDR) begin
            rdata_o[W-1:0] = rx_i;
        end
    end

    // R2/R9: chip-select moves only on a control-register write
    a_r2_cs_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cs_n_o));
endmodule

// File: rtl/spi_byte_bridge.sv
module spi_byte_bridge #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned W      = spi_bridge_pkg::XFER_W,
    parameter int unsigned DIV    = spi_bridge_pkg::SCK_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    input  logic              spi_miso
);
    logic         start, busy, dav, rise, fall;
    logic [W-1:0] tx_byte, rx_byte;

    spi_bridge_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .dav_i(dav), .rx_i(rx_byte),
        .cs_n_o(spi_cs_n), .start_o(start), .tx_o(tx_byte), .rdata_o(bus_rdata)
    );

    spi_clk_div #(.DIV(DIV)) div_i (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .rise_o(rise), .fall_o(fall)
    );

    spi_shift_engine #(.W(W)) eng_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tx_i(tx_byte),
        .rise_i(rise), .fall_i(fall), .miso_i(spi_miso),
        .busy_o(busy), .dav_o(dav), .sclk_o(spi_sclk), .mosi_o(spi_mosi),
        .rx_o(rx_byte)
    );

    // R1: reset leaves the serial side quiet and chip-select released
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (spi_cs_n && !spi_sclk && !spi_mosi));
endmodule

// File: tb/spi_byte_bridge_tb.sv
module spi_byte_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h70;
    localparam logic [7:0] A_DATA = 8'h74;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, cs_n, miso;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_byte_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_cs_n(cs_n), .spi_miso(miso)
    );

    // behavioural mode-0 slave
    logic [7:0] s_reply = 8'h00;
    logic [7:0] s_got = 8'h00;
    int s_rises = 0;
    int s_falls = 0;
    int hi_cnt  = 0;
    assign miso = s_reply[7 - (s_falls % 8)];
    always @(posedge sclk) begin
        s_got   <= {s_got[6:0], mosi};
        s_rises <= s_rises + 1;
    end
    always @(negedge sclk) s_falls <= s_falls + 1;
    always @(negedge clk) if (sclk) hi_cnt <= hi_cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_dav(output int n);
        logic [31:0] v;
        n = 0;
        bus_read(A_CTRL, v);
        while (!v[1] && n < 200) begin
            @(negedge clk);
            n++;
            bus_read(A_CTRL, v);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
        chk(mosi == 1'b0, "R1 mosi", 32'(mosi), 0);
        bus_read(A_CTRL, v);
        chk(v == 32'h1, "R1 ctrl", v, 32'h1);
    endtask

    task automatic t_cs(input logic lvl);
        bus_write(A_CTRL, {31'b0, lvl});
        chk(cs_n == lvl, "R2 cs_n follows ctrl bit0", 32'(cs_n), 32'(lvl));
    endtask

    task automatic t_xfer(input logic [7:0] tx, input logic [7:0] reply);
        logic [31:0] v;
        int n, r0, h0;
        logic cs0;
        s_reply = reply;
        r0 = s_rises; h0 = hi_cnt; cs0 = cs_n;
        bus_write(A_DATA, {24'b0, tx});
        bus_read(A_CTRL, v);
        chk(v[1] == 1'b0, "R3 dav cleared", v, {v[31:2], 1'b0, v[0]});
        wait_dav(n);
        chk(n == 48, "R6 dav delay", n, 48);
        chk(s_rises - r0 == 8, "R5 pulse count", s_rises - r0, 8);
        chk(hi_cnt - h0 == 24, "R5 high clocks", hi_cnt - h0, 24);
        chk(sclk == 1'b0, "R5 sclk idle", 32'(sclk), 0);
        chk(s_got == tx, "R4 mosi msb first", 32'(s_got), 32'(tx));
        bus_read(A_DATA, v);
        chk(v == {24'b0, reply}, "R7 rx byte", v, {24'b0, reply});
        chk(cs_n == cs0, "R2 cs untouched by transfer", 32'(cs_n), 32'(cs0));
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        int n, r0;
        s_reply = 8'h5E;
        r0 = s_rises;
        bus_write(A_DATA, 32'h81);
        repeat (10) @(negedge clk);
        bus_write(A_DATA, 32'hFF);
        wait_dav(n);
        chk(n == 36, "R8 timing kept", n, 36);
        chk(s_got == 8'h81, "R8 byte kept", 32'(s_got), 32'h81);
        repeat (60) @(negedge clk);
        chk(s_rises - r0 == 8, "R8 no extra transfer", s_rises - r0, 8);
        bus_read(A_DATA, v);
        chk(v == 32'h5E, "R8 rx intact", v, 32'h5E);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        int r0;
        logic cs0;
        r0 = s_rises; cs0 = cs_n;
        bus_write(8'h78, {31'b0, ~cs0});
        bus_write(8'h71, {31'b0, ~cs0});
        chk(cs_n == cs0, "R9 stray write keeps cs", 32'(cs_n), 32'(cs0));
        bus_read(8'h78, v);
        chk(v == 32'h0, "R9 unmapped read", v, 0);
        repeat (60) @(negedge clk);
        chk(s_rises == r0, "R9 stray write starts nothing", s_rises - r0, 0);
        bus_read(A_CTRL, v);
        chk(v[1] == 1'b1, "R9 dav at bit1", v, {v[31:2], 1'b1, v[0]});
        chk(v[0] == cs_n, "R9 cs at bit0", 32'(v[0]), 32'(cs_n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cs(1'b0);
        t_xfer(8'hA5, 8'h3C);
        t_xfer(8'h01, 8'h80);
        t_xfer(8'hFE, 8'h7F);
        t_busy_write();
        t_decode();
        t_xfer(8'h00, 8'hFF);
        t_cs(1'b1);
        t_xfer(8'hC3, 8'h96);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule